// File: doc/BRIEF.md
# Tiled Layout Address Generator

This block turns a two-dimensional element coordinate (row, column) into the linear memory offset that the element occupies when the array is stored as a grid of rectangular tiles. The tiles are placed row after row over the array, and inside each tile the elements are also placed row after row. When the array bounds are not multiples of the tile size, the edge tiles are padded out to full size. The contents of those padding slots are left undefined.

Each request carries the array bounds, the tile height and width as base-two logarithms, and the coordinate. A valid/ready handshake moves requests through a two-stage pipeline. The block accepts one request per cycle while the output side is not stalled. Besides the offset, the block returns the tile index and the within-tile index as a debug aid.

A request can instead ask for the default tile. In that case the tile height follows from the row count and the width is 128. A coordinate outside the array is flagged as an error and carries no address.

Top module: `tile_addr_gen`

## Requirements
- R1: For an in-range coordinate, `out_offset` = (tile_row × tiles_per_row + tile_col) × tile_h × tile_w + in_row × tile_w + in_col, reduced modulo 2^OFF_W. Example: a 3×5 array with 2×2 tiles maps element (2,3) to offset 17.
- R2: `out_tile_row` = floor(row / tile_h) and `out_in_row` = row mod tile_h. Likewise `out_tile_col` = floor(col / tile_w) and `out_in_col` = col mod tile_w. The tile height is 2^`tile_h_log2` and the tile width is 2^`tile_w_log2`.
- R3: tiles_per_row is ceil(cols / tile_w), so a column count that is not a multiple of the tile width still reserves a whole padded tile at the end of each tile row.
- R4: When `auto_tile` is 1, `tile_h_log2` and `tile_w_log2` are ignored. The tile width is then 128. The tile height is 2 for a row count of 2 or less, 4 for a row count of 3 or 4, and 8 otherwise.
- R5: A coordinate with row ≥ `arr_rows` or col ≥ `arr_cols` gives `out_err` = 1 with the offset and all four index outputs at 0. Otherwise `out_err` = 0.
- R6: With `out_ready` held at 1, a request accepted at one rising edge (`in_valid` and `in_ready` both 1) shows `out_valid` = 1 with its result after the next rising edge, and not before.
- R7: While `out_valid` = 1 and `out_ready` = 0, all outputs hold their values. Results leave in the order the requests were accepted, with none lost or duplicated.
- R8: `in_ready` is 0 only when both pipeline stages hold a result and `out_ready` is 0. Otherwise one request per cycle is accepted.
- R9: During reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when in_valid is 1 |
| arr_rows | input | ROW_W | Array row count |
| arr_cols | input | COL_W | Array column count |
| auto_tile | input | 1 | 1: use the default tile chosen from arr_rows |
| tile_h_log2 | input | LOG_W | log2 of tile height |
| tile_w_log2 | input | LOG_W | log2 of tile width |
| coord_row | input | ROW_W | Element row |
| coord_col | input | COL_W | Element column |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_err | output | 1 | Coordinate outside the array |
| out_offset | output | OFF_W | Linear element offset |
| out_tile_row | output | ROW_W | Tile row index |
| out_tile_col | output | COL_W | Tile column index |
| out_in_row | output | ROW_W | Row inside the tile |
| out_in_col | output | COL_W | Column inside the tile |

## Verification
Every result is due one rising edge after the edge that accepts its request. Results are held for as long as `out_ready` is low.

The bench drives inputs on the falling edge and samples just after it. It records an expected result at each accepting edge and compares it at the edge where the output is taken, so stalls of any length keep the pairing exact. One directed case with `out_ready` high checks that `out_valid` is still low after the accepting edge and high after the next edge. Stalled cycles are checked separately to confirm the output held its value.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  // default-tile width (log2) and heights chosen by the row count
  localparam int AUTO_W_LOG2 = 7;

  typedef enum logic [1:0] {
    TH_2 = 2'd1,
    TH_4 = 2'd2,
    TH_8 = 2'd3
  } auto_h_e;

  function automatic auto_h_e auto_height(input int unsigned rows);
    if (rows <= 2)      return TH_2;
    else if (rows <= 4) return TH_4;
    else                return TH_8;
  endfunction
endpackage

// File: rtl/tile_shape_sel.sv
module tile_shape_sel
  import tile_addr_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int LOG_W   = 4,
  parameter bit AUTO_EN = 1'b1
) (
  input  logic [ROW_W-1:0] rows,
  input  logic             auto_tile,
  input  logic [LOG_W-1:0] h_log2_in,
  input  logic [LOG_W-1:0] w_log2_in,
  output logic [LOG_W-1:0] h_log2,
  output logic [LOG_W-1:0] w_log2
);
  generate
    if (AUTO_EN) begin : g_auto
      auto_h_e sel;
      always_comb begin
        sel = auto_height(int'(rows));
        if (auto_tile) begin
          h_log2 = LOG_W'(sel);
          w_log2 = LOG_W'(AUTO_W_LOG2);
        end else begin
          h_log2 = h_log2_in;
          w_log2 = w_log2_in;
        end
      end
    end else begin : g_fixed
      logic unused_auto;
      assign unused_auto = auto_tile ^ (^rows);
      assign h_log2 = h_log2_in;
      assign w_log2 = w_log2_in;
    end
  endgenerate
endmodule

// File: rtl/tile_decomp.sv
module tile_decomp #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int LOG_W = 4
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] rows,
  input  logic [COL_W-1:0] cols,
  input  logic [LOG_W-1:0] h_log2,
  input  logic [LOG_W-1:0] w_log2,
  output logic             err,
  output logic [ROW_W-1:0] tile_row,
  output logic [COL_W-1:0] tile_col,
  output logic [ROW_W-1:0] in_row,
  output logic [COL_W-1:0] in_col,
  output logic [COL_W:0]   tiles_per_row
);
  localparam int EXT_W = COL_W + (1 << LOG_W);

  logic [EXT_W-1:0] bias;
  logic [ROW_W-1:0] tr;
  logic [COL_W-1:0] tc;

  always_comb begin
    err  = (row >= rows) || (col >= cols);
    tr   = row >> h_log2;
    tc   = col >> w_log2;
    bias = (EXT_W'(1) << w_log2) - EXT_W'(1);
    tiles_per_row = (COL_W+1)'((EXT_W'(cols) + bias) >> w_log2);
    if (err) begin
      tile_row = '0;
      tile_col = '0;
      in_row   = '0;
      in_col   = '0;
    end else begin
      tile_row = tr;
      tile_col = tc;
      in_row   = row - (tr << h_log2);
      in_col   = col - (tc << w_log2);
    end
  end
endmodule

// File: rtl/tile_linear.sv
module tile_linear #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int LOG_W = 4,
  parameter int OFF_W = 32
) (
  input  logic [ROW_W-1:0] tile_row,
  input  logic [COL_W-1:0] tile_col,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic [COL_W:0]   tiles_per_row,
  input  logic [LOG_W-1:0] h_log2,
  input  logic [LOG_W-1:0] w_log2,
  output logic [OFF_W-1:0] offset
);
  logic [OFF_W-1:0] tile_lin;
  logic [LOG_W:0]   tile_sh;

  always_comb begin
    tile_sh  = (LOG_W+1)'(h_log2) + (LOG_W+1)'(w_log2);
    tile_lin = OFF_W'(tile_row) * OFF_W'(tiles_per_row) + OFF_W'(tile_col);
    offset   = (tile_lin << tile_sh) + (OFF_W'(in_row) << w_log2) + OFF_W'(in_col);
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 10,
  parameter int LOG_W   = 4,
  parameter int OFF_W   = 32,
  parameter bit AUTO_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ROW_W-1:0] arr_rows,
  input  logic [COL_W-1:0] arr_cols,
  input  logic             auto_tile,
  input  logic [LOG_W-1:0] tile_h_log2,
  input  logic [LOG_W-1:0] tile_w_log2,
  input  logic [ROW_W-1:0] coord_row,
  input  logic [COL_W-1:0] coord_col,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_err,
  output logic [OFF_W-1:0] out_offset,
  output logic [ROW_W-1:0] out_tile_row,
  output logic [COL_W-1:0] out_tile_col,
  output logic [ROW_W-1:0] out_in_row,
  output logic [COL_W-1:0] out_in_col
);
  // stage 1: decomposed coordinate
  logic             s1_valid, s1_valid_nxt;
  logic             s1_err;
  logic [ROW_W-1:0] s1_tr, s1_ir;
  logic [COL_W-1:0] s1_tc, s1_ic;
  logic [COL_W:0]   s1_tpr;
  logic [LOG_W-1:0] s1_lh, s1_lw;
  // stage 2: final result
  logic             s2_valid, s2_valid_nxt;
  logic             s2_err;
  logic [OFF_W-1:0] s2_off;
  logic [ROW_W-1:0] s2_tr, s2_ir;
  logic [COL_W-1:0] s2_tc, s2_ic;
  logic [LOG_W-1:0] s2_lh, s2_lw;

  logic             adv1, adv2, load1, load2;
  logic [LOG_W-1:0] sel_lh, sel_lw;
  logic             d_err;
  logic [ROW_W-1:0] d_tr, d_ir;
  logic [COL_W-1:0] d_tc, d_ic;
  logic [COL_W:0]   d_tpr;
  logic [OFF_W-1:0] lin_off;

  tile_shape_sel #(.ROW_W(ROW_W), .LOG_W(LOG_W), .AUTO_EN(AUTO_EN)) u_shape (
    .rows(arr_rows), .auto_tile(auto_tile),
    .h_log2_in(tile_h_log2), .w_log2_in(tile_w_log2),
    .h_log2(sel_lh), .w_log2(sel_lw)
  );

  tile_decomp #(.ROW_W(ROW_W), .COL_W(COL_W), .LOG_W(LOG_W)) u_decomp (
    .row(coord_row), .col(coord_col), .rows(arr_rows), .cols(arr_cols),
    .h_log2(sel_lh), .w_log2(sel_lw), .err(d_err),
    .tile_row(d_tr), .tile_col(d_tc), .in_row(d_ir), .in_col(d_ic),
    .tiles_per_row(d_tpr)
  );

  tile_linear #(.ROW_W(ROW_W), .COL_W(COL_W), .LOG_W(LOG_W), .OFF_W(OFF_W)) u_linear (
    .tile_row(s1_tr), .tile_col(s1_tc), .in_row(s1_ir), .in_col(s1_ic),
    .tiles_per_row(s1_tpr), .h_log2(s1_lh), .w_log2(s1_lw), .offset(lin_off)
  );

  // handshake and next state
  always_comb begin
    adv2         = !s2_valid || out_ready;
    adv1         = !s1_valid || adv2;
    load1        = adv1 && in_valid;
    load2        = adv2 && s1_valid;
    s1_valid_nxt = adv1 ? in_valid : s1_valid;
    s2_valid_nxt = adv2 ? s1_valid : s2_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else begin
      s1_valid <= s1_valid_nxt;
      s2_valid <= s2_valid_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (load1) begin
      s1_err <= d_err;
      s1_tr  <= d_tr;
      s1_tc  <= d_tc;
      s1_ir  <= d_ir;
      s1_ic  <= d_ic;
      s1_tpr <= d_tpr;
      s1_lh  <= sel_lh;
      s1_lw  <= sel_lw;
    end
  end

  always_ff @(posedge clk) begin
    if (load2) begin
      s2_err <= s1_err;
      s2_off <= s1_err ? '0 : lin_off;
      s2_tr  <= s1_tr;
      s2_tc  <= s1_tc;
      s2_ir  <= s1_ir;
      s2_ic  <= s1_ic;
      s2_lh  <= s1_lh;
      s2_lw  <= s1_lw;
    end
  end

  assign in_ready     = adv1;
  assign out_valid    = s2_valid;
  assign out_err      = s2_err;
  assign out_offset   = s2_off;
  assign out_tile_row = s2_tr;
  assign out_tile_col = s2_tc;
  assign out_in_row   = s2_ir;
  assign out_in_col   = s2_ic;
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int LOG_W = 4,
  parameter int OFF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_err,
  input logic [OFF_W-1:0] out_offset,
  input logic [ROW_W-1:0] out_in_row,
  input logic [COL_W-1:0] out_in_col,
  input logic             s1_valid,
  input logic [LOG_W-1:0] s2_lh,
  input logic [LOG_W-1:0] s2_lw
);
  localparam int CMP_W = ROW_W + (1 << LOG_W) + 1;

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_offset) && $stable(out_err)); // R7

  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_offset == '0 && out_in_row == '0 && out_in_col == '0); // R5

  AST_COL_IN_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |->
      (out_offset & ((OFF_W'(1) << s2_lw) - OFF_W'(1))) == OFF_W'(out_in_col)); // R1

  AST_IN_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> CMP_W'(out_in_row) < (CMP_W'(1) << s2_lh)); // R2

  AST_FULL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && out_valid && !out_ready |-> !in_ready); // R8
endmodule

bind tile_addr_gen tile_addr_gen_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .LOG_W(LOG_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/tile_addr_gen_bench.sv
`timescale 1ns/1ps
module tile_addr_gen_bench;
  localparam int ROW_W = 10;
  localparam int COL_W = 10;
  localparam int LOG_W = 4;
  localparam int OFF_W = 32;

  typedef struct packed {
    logic             err;
    logic [OFF_W-1:0] off;
    logic [ROW_W-1:0] tr;
    logic [COL_W-1:0] tc;
    logic [ROW_W-1:0] ir;
    logic [COL_W-1:0] ic;
  } exp_t;

  logic             clk, rst_n;
  logic             in_valid, in_ready, auto_tile;
  logic [ROW_W-1:0] arr_rows, coord_row;
  logic [COL_W-1:0] arr_cols, coord_col;
  logic [LOG_W-1:0] tile_h_log2, tile_w_log2;
  logic             out_valid, out_ready, out_err;
  logic [OFF_W-1:0] out_offset;
  logic [ROW_W-1:0] out_tile_row, out_in_row;
  logic [COL_W-1:0] out_tile_col, out_in_col;

  int   n_chk, n_bad;
  exp_t sb[$];
  logic prev_stall;
  logic [OFF_W-1:0] prev_off;
  int   stall_pct;

  tile_addr_gen u_tile_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .arr_rows(arr_rows), .arr_cols(arr_cols), .auto_tile(auto_tile),
    .tile_h_log2(tile_h_log2), .tile_w_log2(tile_w_log2),
    .coord_row(coord_row), .coord_col(coord_col),
    .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
    .out_offset(out_offset), .out_tile_row(out_tile_row),
    .out_tile_col(out_tile_col), .out_in_row(out_in_row), .out_in_col(out_in_col)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic exp_t model(input int rows, input int cols, input bit aut,
                                 input int lh, input int lw, input int r, input int c);
    exp_t e;
    longint th, tw, tpr, o;
    if (aut) begin
      th = (rows <= 2) ? 2 : (rows <= 4) ? 4 : 8; // R4
      tw = 128;
    end else begin
      th = longint'(1) << lh;
      tw = longint'(1) << lw;
    end
    e = '0;
    if (r >= rows || c >= cols) begin
      e.err = 1'b1; // R5
      return e;
    end
    tpr  = (cols + tw - 1) / tw; // R3
    e.tr = ROW_W'(r / th);
    e.ir = ROW_W'(r % th);
    e.tc = COL_W'(c / tw);
    e.ic = COL_W'(c % tw);
    o = ((r / th) * tpr + (c / tw)) * th * tw + (r % th) * tw + (c % tw);
    e.off = OFF_W'(o);
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: scoreboard push at accept, compare at take, hold check on stall
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid && out_offset == prev_off, "R7", "held offset",
              longint'(out_offset), longint'(prev_off));
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_err == e.err, "R5", "err", longint'(out_err), longint'(e.err));
          check(out_offset == e.off, "R1", "offset", longint'(out_offset), longint'(e.off));
          check(out_tile_row == e.tr && out_tile_col == e.tc, "R2", "tile index",
                longint'({out_tile_row, out_tile_col}), longint'({e.tr, e.tc}));
          check(out_in_row == e.ir && out_in_col == e.ic, "R2", "in-tile index",
                longint'({out_in_row, out_in_col}), longint'({e.ir, e.ic}));
        end
      end
      if (in_valid && in_ready)
        sb.push_back(model(int'(arr_rows), int'(arr_cols), auto_tile,
                           int'(tile_h_log2), int'(tile_w_log2),
                           int'(coord_row), int'(coord_col)));
      prev_stall = out_valid && !out_ready;
      prev_off   = out_offset;
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input int rows, input int cols, input bit aut,
                      input int lh, input int lw, input int r, input int c);
    bit acc;
    arr_rows    = ROW_W'(rows);
    arr_cols    = COL_W'(cols);
    auto_tile   = aut;
    tile_h_log2 = LOG_W'(lh);
    tile_w_log2 = LOG_W'(lw);
    coord_row   = ROW_W'(r);
    coord_col   = COL_W'(c);
    in_valid    = 1'b1;
    do begin
      out_ready = ($urandom_range(99) >= stall_pct);
      #2;
      acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic sweep(input int rows, input int cols, input bit aut,
                       input int lh, input int lw);
    for (int r = 0; r <= rows; r++)
      for (int c = 0; c <= cols; c++)
        send(rows, cols, aut, lh, lw, r, c);
  endtask

  initial begin
    #(5ns * 150000);
    n_bad++;
    $display("FAIL R6 watchdog expired: actual hung expected done");
    report();
  end

  initial begin
    void'($urandom(32'h5eed_71e5));
    n_chk = 0; n_bad = 0; prev_stall = 1'b0; prev_off = '0; stall_pct = 0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; auto_tile = 1'b0;
    arr_rows = '0; arr_cols = '0; tile_h_log2 = '0; tile_w_log2 = '0;
    coord_row = '0; coord_col = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid in reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 latency, R1 worked example: 3x5 array, 2x2 tiles, (2,3) -> 17
    arr_rows = 3; arr_cols = 5; auto_tile = 0; tile_h_log2 = 1; tile_w_log2 = 1;
    coord_row = 2; coord_col = 3; in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check(out_valid == 1'b0, "R6", "valid after accept edge", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6", "valid after next edge", longint'(out_valid), 1);
    check(out_offset == 17, "R1", "example offset", longint'(out_offset), 17);
    @(negedge clk);

    // R8 back-pressure: fill both stages with out_ready low
    out_ready = 0;
    coord_row = 0; coord_col = 0; in_valid = 1;
    @(negedge clk);
    @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R8", "in_ready when full", longint'(in_ready), 0);
    in_valid = 0;
    @(negedge clk);
    out_ready = 1;
    repeat (3) @(negedge clk);

    // exhaustive sweeps incl. non-multiple bounds (R3) and out-of-range (R5)
    stall_pct = 0;
    sweep(3, 5, 0, 1, 1);
    sweep(5, 7, 0, 1, 2);
    stall_pct = 30;
    sweep(9, 10, 0, 2, 3);
    sweep(6, 3, 0, 0, 1);
    sweep(1, 1, 0, 0, 0);
    // R4 default tile: rows select heights 2, 4, 8; width 128
    sweep(2, 130, 1, 9, 9);
    sweep(4, 140, 1, 0, 0);
    sweep(11, 150, 1, 3, 2);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int rows, cols, lh, lw, r, c;
      bit aut;
      rows = $urandom_range(40, 1);
      cols = $urandom_range(300, 1);
      aut  = ($urandom_range(3) == 0);
      lh   = $urandom_range(4);
      lw   = $urandom_range(7);
      r    = $urandom_range(rows + 2);
      c    = $urandom_range(cols + 2);
      send(rows, cols, aut, lh, lw, r, c);
    end

    out_ready = 1;
    repeat (6) @(negedge clk);
    check(sb.size() == 0, "R7", "results outstanding", sb.size(), 0);
    report();
  end
endmodule